// File: doc/BRIEF.md
# Advanced Load Address Table

This block keeps a small associative record of loads that were hoisted above stores they might alias. Each time the pipeline issues such an early load, it records the destination register number with the 8-byte word and the byte lanes that the load touched. Every store is compared against all recorded entries. An entry whose lanes overlap the store is dropped, because the early value may now be stale.

Later a check presents a register number. A hit means the early load is still good. A miss means the consumer must redo the load or branch to recovery. A clearing check also removes the entry it hit. An early load that deferred a fault writes no entry, and it removes any entry already held for its register, so a check on that register misses. Hit or miss is a combinational answer drawn from the table contents at the start of the cycle. All updates take effect at the next clock edge.

Top module: `spec_addr_table`

## Requirements
- R1: After reset the table is empty and every check misses.
- R2: After an insert with `ins_defer` low, a check on that register hits from the next cycle onward until something removes the entry. `chk_hit` is combinational and reflects the table as it stood at the start of the cycle.
- R3: A store removes every entry that overlaps it. Overlap means both use the same address bits [ADDR_W-1:3] and their byte lanes intersect. The lanes are derived from the address bits [2:0] and the size code: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Accesses are naturally aligned.
- R4: A store that shares no byte lane with an entry, or that falls in another 8-byte word, leaves that entry in place.
- R5: When `chk_clr` is high and the check hits, the entry is removed at the clock edge. A check with `chk_clr` low does not change the table.
- R6: An insert with `ins_defer` high creates no entry and removes any existing entry for that register.
- R7: An insert to a register that already has an entry overwrites it. Only the new address is compared against later stores.
- R8: The table holds 16 entries. An insert for a new register into a full table evicts the least recently allocated entry, and an overwrite counts as a fresh allocation. The evicted register then misses.
- R9: Within one cycle the operations apply in this order: clearing check, then insert, then store. A store that overlaps a same-cycle insert kills the new entry. A clear and an insert for the same register leave the new entry in place.
- R10: `chk_hit` is low whenever `chk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Early-load insert request |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| ins_size | input | 2 | Size code of the early load (0..3 = 1,2,4,8 bytes) |
| ins_defer | input | 1 | Early load deferred a fault; record nothing |
| st_valid | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register being checked |
| chk_clr | input | 1 | Remove the entry on hit |
| chk_hit | output | 1 | Entry present for `chk_reg` |

## Verification
Properties evaluated every cycle cover the following: a check one cycle after an insert hits unless the same-cycle store overlapped it; a deferred insert or an overlapping same-cycle store leaves a miss; a clearing hit is followed by a miss on the same register; and there is never a hit without a request. Eviction order in a full table, partial-lane overlap, overwrite of a register's address, and long interleavings of inserts, stores and checks depend on history deeper than a property can hold. Only the bench's directed and random scenarios, compared with a timestamp-based model, can show them.

// File: rtl/spec_addr_table.sv
module spec_addr_table #(
  parameter int N      = 16,
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_size,
  input  logic              ins_defer,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clr,
  output logic              chk_hit
);
  localparam int AGE_W  = $clog2(N);
  localparam int WORD_W = ADDR_W - 3;

  logic [N-1:0]              vld, vld_n;
  logic [N-1:0][REG_W-1:0]   ereg, ereg_n;
  logic [N-1:0][WORD_W-1:0]  eword, eword_n;
  logic [N-1:0][7:0]         elane, elane_n;
  logic [N-1:0][AGE_W-1:0]   eage, eage_n;
  logic [N-1:0]              chk_match;

  function automatic logic [7:0] lanes(input logic [2:0] off, input logic [1:0] sz);
    logic [7:0] m;
    case (sz)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m << off;
  endfunction

  function automatic logic overlaps(input logic [ADDR_W-1:0] a, input logic [1:0] asz,
                                    input logic [ADDR_W-1:0] b, input logic [1:0] bsz);
    return (a[ADDR_W-1:3] == b[ADDR_W-1:3]) && |(lanes(a[2:0], asz) & lanes(b[2:0], bsz));
  endfunction

  function automatic logic [N-1:0][AGE_W-1:0] compact(input logic [N-1:0] v,
                                                      input logic [N-1:0][AGE_W-1:0] a,
                                                      input logic [N-1:0] k);
    logic [N-1:0][AGE_W-1:0] r;
    logic [AGE_W:0] dec;
    r = a;
    for (int j = 0; j < N; j++) begin
      dec = '0;
      for (int i = 0; i < N; i++)
        if (v[i] && k[i] && a[i] < a[j]) dec = dec + 1'b1;
      if (v[j] && !k[j]) r[j] = a[j] - dec[AGE_W-1:0];
    end
    return r;
  endfunction

  always_comb
    for (int i = 0; i < N; i++)
      chk_match[i] = vld[i] && (ereg[i] == chk_reg);

  assign chk_hit = chk_valid && |chk_match;

  logic [N-1:0]       kill_clr, kill_def, kill_st, ins_match, v1, v2;
  logic [N-1:0][AGE_W-1:0] a1, a2;
  logic [AGE_W-1:0]   slot;
  logic [AGE_W:0]     old_age;
  logic               found;
  logic [7:0]         st_lanes;

  assign st_lanes = lanes(st_addr[2:0], st_size);
  assign kill_clr = (chk_valid && chk_clr) ? chk_match : '0;

  always_comb begin
    v1 = vld & ~kill_clr;
    a1 = compact(vld, eage, kill_clr);
    ereg_n  = ereg;
    eword_n = eword;
    elane_n = elane;
    for (int i = 0; i < N; i++)
      ins_match[i] = v1[i] && (ereg[i] == ins_reg);

    kill_def = (ins_valid && ins_defer) ? ins_match : '0;
    v2 = v1 & ~kill_def;
    a2 = compact(v1, a1, kill_def);

    slot  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++)
      if (!found && ins_match[i]) begin slot = AGE_W'(i); found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && !v2[i]) begin slot = AGE_W'(i); found = 1'b1; end
    for (int i = 0; i < N; i++)
      if (!found && a2[i] == AGE_W'(N - 1)) begin slot = AGE_W'(i); found = 1'b1; end
    old_age = v2[slot] ? {1'b0, a2[slot]} : (AGE_W+1)'(N);

    if (ins_valid && !ins_defer) begin
      for (int j = 0; j < N; j++)
        if (v2[j] && AGE_W'(j) != slot && {1'b0, a2[j]} < old_age)
          a2[j] = a2[j] + 1'b1;
      a2[slot]      = '0;
      v2[slot]      = 1'b1;
      ereg_n[slot]  = ins_reg;
      eword_n[slot] = ins_addr[ADDR_W-1:3];
      elane_n[slot] = lanes(ins_addr[2:0], ins_size);
    end

    for (int i = 0; i < N; i++)
      kill_st[i] = st_valid && v2[i] && (eword_n[i] == st_addr[ADDR_W-1:3]) &&
                   |(elane_n[i] & st_lanes);
    eage_n = compact(v2, a2, kill_st);
    vld_n  = v2 & ~kill_st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      eage <= '0;
    end else begin
      vld  <= vld_n;
      eage <= eage_n;
    end
    ereg  <= ereg_n;
    eword <= eword_n;
    elane <= elane_n;
  end

  logic ins_st_ovl;
  assign ins_st_ovl = st_valid && overlaps(ins_addr, ins_size, st_addr, st_size);

  p_insert_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ins_valid && !ins_defer && !ins_st_ovl) &&
     chk_valid && chk_reg == $past(ins_reg)) |-> chk_hit);

  p_same_cycle_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ins_valid && !ins_defer && ins_st_ovl) &&
     chk_valid && chk_reg == $past(ins_reg)) |-> !chk_hit);

  p_defer_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ins_valid && ins_defer) &&
     chk_valid && chk_reg == $past(ins_reg)) |-> !chk_hit);

  p_clear_removes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(chk_hit && chk_clr) &&
     !$past(ins_valid && !ins_defer && ins_reg == chk_reg) &&
     chk_valid && chk_reg == $past(chk_reg)) |-> !chk_hit);

  p_no_idle_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !chk_hit);
endmodule

// File: tb/spec_addr_table_tb_top.sv
module spec_addr_table_tb_top;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_defer = 0, st_valid = 0, chk_valid = 0, chk_clr = 0;
  logic [6:0] ins_reg = 0, chk_reg = 0;
  logic [31:0] ins_addr = 0, st_addr = 0;
  logic [1:0] ins_size = 0, st_size = 0;
  logic chk_hit;
  int nchk = 0, nfail = 0, stamp = 0;
  bit done = 0;

  bit        mv[N];
  int        mreg[N], mstamp[N];
  logic [28:0] mword[N];
  logic [7:0] mlane[N];

  always #4 clk = ~clk;

  spec_addr_table dut_i (.clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_reg(ins_reg),
    .ins_addr(ins_addr), .ins_size(ins_size), .ins_defer(ins_defer), .st_valid(st_valid),
    .st_addr(st_addr), .st_size(st_size), .chk_valid(chk_valid), .chk_reg(chk_reg),
    .chk_clr(chk_clr), .chk_hit(chk_hit));

  function automatic logic [7:0] blanes(input logic [31:0] a, input logic [1:0] sz);
    logic [7:0] m = 0;
    int nb = 1 << sz;
    for (int b = 0; b < 8; b++)
      if (b >= a[2:0] && b < a[2:0] + nb) m[b] = 1'b1;
    return m;
  endfunction

  function automatic bit mhit(input int r);
    for (int i = 0; i < N; i++) if (mv[i] && mreg[i] == r) return 1;
    return 0;
  endfunction

  task automatic mupdate();
    int s;
    if (chk_valid && chk_clr)
      for (int i = 0; i < N; i++) if (mv[i] && mreg[i] == chk_reg) mv[i] = 0;
    if (ins_valid) begin
      s = -1;
      for (int i = 0; i < N; i++) if (mv[i] && mreg[i] == ins_reg) s = i;
      if (ins_defer) begin
        if (s >= 0) mv[s] = 0;
      end else begin
        if (s < 0) for (int i = 0; i < N; i++) if (s < 0 && !mv[i]) s = i;
        if (s < 0) begin
          s = 0;
          for (int i = 1; i < N; i++) if (mstamp[i] < mstamp[s]) s = i;
        end
        mv[s] = 1; mreg[s] = ins_reg; mword[s] = ins_addr[31:3];
        mlane[s] = blanes(ins_addr, ins_size); mstamp[s] = stamp++;
      end
    end
    if (st_valid)
      for (int i = 0; i < N; i++)
        if (mv[i] && mword[i] == st_addr[31:3] && |(mlane[i] & blanes(st_addr, st_size))) mv[i] = 0;
  endtask

  task automatic cyc(input bit iv, input int ir, input logic [31:0] ia, input int isz, input bit idf,
                     input bit sv, input logic [31:0] sa, input int ssz,
                     input bit cv, input int cr, input bit cc, input string tag);
    bit exp;
    @(negedge clk);
    ins_valid = iv; ins_reg = 7'(ir); ins_addr = ia; ins_size = 2'(isz); ins_defer = idf;
    st_valid = sv; st_addr = sa; st_size = 2'(ssz);
    chk_valid = cv; chk_reg = 7'(cr); chk_clr = cc;
    #2;
    exp = cv ? mhit(cr) : 0;
    nchk++;
    if (chk_hit !== exp) begin
      nfail++;
      $display("FAIL %s reg=%0d got=%0b exp=%0b", tag, cr, chk_hit, exp);
    end
    mupdate();
  endtask

  task automatic chk(input int r, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, r, 0, tag);
  endtask
  task automatic ins(input int r, input logic [31:0] a, input int sz);
    cyc(1, r, a, sz, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask
  task automatic st(input logic [31:0] a, input int sz);
    cyc(0, 0, 0, 0, 0, 1, a, sz, 0, 0, 0, "R10");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int r, sz, isz, ssz;
    logic [31:0] a, b;
    void'($urandom(32'h5EED_0A17));
    for (int i = 0; i < N; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 4; i++) chk(i * 9, "R1");

    ins(3, 32'h100, 3); chk(3, "R2");
    st(32'h108, 3); chk(3, "R4");
    st(32'h104, 2); chk(3, "R3");
    ins(4, 32'h203, 0); st(32'h200, 1); chk(4, "R4");
    st(32'h202, 1); chk(4, "R3");
    ins(5, 32'h300, 2); ins(5, 32'h400, 2); st(32'h300, 2); chk(5, "R7");
    st(32'h400, 3); chk(5, "R7");
    ins(6, 32'h500, 3); cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 0, "R5"); chk(6, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 1, "R5"); chk(6, "R5");
    ins(7, 32'h600, 3); cyc(1, 7, 32'h700, 3, 1, 0, 0, 0, 0, 0, 0, "R6"); chk(7, "R6");
    cyc(1, 8, 32'h800, 3, 0, 1, 32'h804, 0, 0, 0, 0, "R9"); chk(8, "R9");
    ins(9, 32'h900, 3); cyc(1, 9, 32'hA00, 3, 0, 0, 0, 0, 1, 9, 1, "R9"); chk(9, "R9");
    for (int i = 0; i < N + 1; i++) ins(20 + i, 32'h1000 + 8 * i, 3);
    chk(20, "R8"); chk(21, "R8"); chk(20 + N, "R8");
    ins(21, 32'h2000, 3); ins(50, 32'h2100, 3); chk(21, "R8"); chk(22, "R8");

    for (int n = 0; n < 4000; n++) begin
      r = $urandom % 24;
      isz = $urandom % 4; ssz = $urandom % 4;
      a = {26'd0, 3'($urandom % 6), 3'($urandom % 8)} & ~32'((1 << isz) - 1);
      b = {26'd0, 3'($urandom % 6), 3'($urandom % 8)} & ~32'((1 << ssz) - 1);
      sz = $urandom % 8;
      cyc(sz < 4, r, a, isz, sz == 0, ($urandom % 3) == 0, b, ssz,
          ($urandom % 4) != 0, $urandom % 24, ($urandom % 4) == 0, "R2");
    end
    @(negedge clk);
    ins_valid = 0; st_valid = 0; chk_valid = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule